// File: doc/BRIEF.md
# Program ROM Window Mapper

This block sits between a CPU's upper 32 KB address space (0x8000 to 0xFFFF) and a program ROM that is organised as 8 KB pages. It converts each CPU address into a ROM page number and a byte offset inside that page. Two of the four 8 KB windows can be switched at run time. The top 16 KB always shows the two highest pages of the ROM.

The block also holds a 2-bit nametable arrangement code that the video side reads. The arrangement can be vertical, horizontal, or one of two single-screen settings.

A register changes only when the write strobe is high and the full 16-bit address equals one of three exact values. Every other write is ignored. A page selection that is larger than the ROM folds back into the ROM by taking the remainder modulo the page count.

Top module: `prg_map`

## Requirements
- R1: A write with the address equal to 0x8010 sets the page shown at 0x8000–0x9FFF to the write data modulo PAGE_COUNT. The change is visible from the cycle after the write edge.
- R2: A write with the address equal to 0xA010 sets the page shown at 0xA000–0xBFFF to the write data modulo PAGE_COUNT. The change is visible from the cycle after the write edge.
- R3: Addresses 0xC000–0xDFFF always map to page PAGE_COUNT-2. Addresses 0xE000–0xFFFF always map to page PAGE_COUNT-1. No write changes either mapping.
- R4: A write with the address equal to 0x9400 loads data bits 1:0 into `mirror_mode` and ignores the upper data bits. The codes are 0 = vertical, 1 = horizontal, 2 = single screen A, 3 = single screen B.
- R5: After reset, 0x8000–0x9FFF shows page 0, 0xA000–0xBFFF shows page 1, and `mirror_mode` is 0 (vertical).
- R6: Any write to an address other than the three exact ones leaves all state unchanged. Any cycle with `cpu_wr` low also leaves all state unchanged. Examples of ignored addresses are 0x8011, 0x8000, 0x9401, 0xA011 and 0xF000, and any address below 0x8000.
- R7: `rom_sel` equals address bit 15. `rom_offset` equals address bits 12:0. `rom_page` is 0 whenever `rom_sel` is low.
- R8: While `rom_sel` is high, `rom_page` is always below PAGE_COUNT. This holds for every data value, including 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| rom_sel | output | 1 | High when the address falls in the ROM space |
| rom_page | output | $clog2(PAGE_COUNT) | ROM page number |
| rom_offset | output | 13 | Byte offset within the 8 KB page |
| mirror_mode | output | 2 | Nametable arrangement code |

## Verification
A corrupted page register appears on `rom_page` as soon as the address falls in that register's window. Because the page output is combinational, this can happen in the same cycle the register goes wrong. If the address stays in another region, the fault stays hidden until a read of that window.

A mirror register that took a stray write is visible on `mirror_mode` in the very next cycle. The reference model is compared on every clock, so a missed write or a stray write is reported in the first cycle after the bad edge.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int NUM_SWITCHED = 2;

    localparam logic [15:0] WIN0_SEL_ADDR = 16'h8010;
    localparam logic [15:0] WIN1_SEL_ADDR = 16'hA010;
    localparam logic [15:0] ARRANGE_ADDR  = 16'h9400;

    typedef enum logic [1:0] {
        ARR_VERT  = 2'd0,
        ARR_HORZ  = 2'd1,
        ARR_ONE_A = 2'd2,
        ARR_ONE_B = 2'd3
    } arrange_e;

    function automatic logic [15:0] win_sel_addr(input int idx);
        return (idx == 0) ? WIN0_SEL_ADDR : WIN1_SEL_ADDR;
    endfunction

    function automatic int unsigned fold_page(input logic [7:0] raw, input int unsigned count);
        return int'(raw) % count;
    endfunction

endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_map_pkg::*;
#(
    parameter int PAGE_COUNT = 12,
    localparam int PW = $clog2(PAGE_COUNT)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [15:0]                      addr,
    input  logic [7:0]                       data,
    input  logic                             wr,
    output logic [NUM_SWITCHED-1:0][PW-1:0]  win_page,
    output arrange_e                         arrange
);

    typedef struct packed {
        logic [NUM_SWITCHED-1:0][PW-1:0] win;
        arrange_e                        arr;
    } regs_t;

    regs_t state_d, state_q, reset_val;

    always_comb begin
        reset_val.arr = ARR_VERT;
        for (int i = 0; i < NUM_SWITCHED; i++) begin
            reset_val.win[i] = PW'(i % PAGE_COUNT);
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr) begin
            for (int i = 0; i < NUM_SWITCHED; i++) begin
                if (addr == win_sel_addr(i)) begin
                    state_d.win[i] = PW'(fold_page(data, PAGE_COUNT));
                end
            end
            if (addr == ARRANGE_ADDR) begin
                state_d.arr = arrange_e'(data[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= reset_val;
        end else begin
            state_q <= state_d;
        end
    end

    assign win_page = state_q.win;
    assign arrange  = state_q.arr;

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_map_pkg::*;
#(
    parameter int PAGE_COUNT = 12,
    localparam int PW = $clog2(PAGE_COUNT)
) (
    input  logic [15:0]                      addr,
    input  logic [NUM_SWITCHED-1:0][PW-1:0]  win_page,
    output logic                             sel,
    output logic [PW-1:0]                    page,
    output logic [12:0]                      offset
);

    localparam logic [PW-1:0] FIXED_LO = PW'(PAGE_COUNT - 2);
    localparam logic [PW-1:0] FIXED_HI = PW'(PAGE_COUNT - 1);

    logic [1:0] region;

    assign region = addr[14:13];
    assign sel    = addr[15];
    assign offset = addr[12:0];

    always_comb begin
        page = '0;
        if (sel) begin
            unique case (region)
                2'd0:    page = win_page[0];
                2'd1:    page = win_page[1];
                2'd2:    page = FIXED_LO;
                default: page = FIXED_HI;
            endcase
        end
    end

endmodule

// File: rtl/prg_map.sv
module prg_map
    import prg_map_pkg::*;
#(
    parameter int PAGE_COUNT = 12,
    localparam int PW = $clog2(PAGE_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   cpu_addr,
    input  logic [7:0]    cpu_data,
    input  logic          cpu_wr,
    output logic          rom_sel,
    output logic [PW-1:0] rom_page,
    output logic [12:0]   rom_offset,
    output logic [1:0]    mirror_mode
);

    logic [NUM_SWITCHED-1:0][PW-1:0] win_pages_w;
    arrange_e                        arrange_w;

    prg_bank_regs #(.PAGE_COUNT(PAGE_COUNT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cpu_addr),
        .data     (cpu_data),
        .wr       (cpu_wr),
        .win_page (win_pages_w),
        .arrange  (arrange_w)
    );

    prg_window_map #(.PAGE_COUNT(PAGE_COUNT)) u_map (
        .addr     (cpu_addr),
        .win_page (win_pages_w),
        .sel      (rom_sel),
        .page     (rom_page),
        .offset   (rom_offset)
    );

    assign mirror_mode = arrange_w;

endmodule

// File: rtl/prg_map_chk.sv
module prg_map_chk
    import prg_map_pkg::*;
#(
    parameter int PAGE_COUNT = 12,
    localparam int PW = $clog2(PAGE_COUNT)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [15:0]                      cpu_addr,
    input logic [7:0]                       cpu_data,
    input logic                             cpu_wr,
    input logic                             rom_sel,
    input logic [PW-1:0]                    rom_page,
    input logic [1:0]                       mirror_mode,
    input logic [NUM_SWITCHED-1:0][PW-1:0]  win_pages_w
);

    logic hits_reg;
    assign hits_reg = (cpu_addr == WIN0_SEL_ADDR) || (cpu_addr == WIN1_SEL_ADDR)
                   || (cpu_addr == ARRANGE_ADDR);

    // R1
    win0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h8010) |=>
            (int'(win_pages_w[0]) == int'($past(cpu_data)) % PAGE_COUNT));

    // R2
    win1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'hA010) |=>
            (int'(win_pages_w[1]) == int'($past(cpu_data)) % PAGE_COUNT));

    // R3
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && cpu_addr[14]) |->
            (int'(rom_page) == PAGE_COUNT - 2 + int'(cpu_addr[13])));

    // R4
    arrange_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h9400) |=> (mirror_mode == $past(cpu_data[1:0])));

    // R6
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr || !hits_reg) |=> ($stable(mirror_mode) && $stable(win_pages_w)));

    // R7
    outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[15] |-> (!rom_sel && rom_page == '0));

    // R8
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (int'(rom_page) < PAGE_COUNT));

endmodule

bind prg_map prg_map_chk #(.PAGE_COUNT(PAGE_COUNT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_data    (cpu_data),
    .cpu_wr      (cpu_wr),
    .rom_sel     (rom_sel),
    .rom_page    (rom_page),
    .mirror_mode (mirror_mode),
    .win_pages_w (win_pages_w)
);

// File: tb/prg_map_tb.sv
`timescale 1ns/1ps
module prg_map_tb;

    localparam int PC = 12;
    localparam int PW = $clog2(PC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    cpu_data = '0;
    logic          cpu_wr = 1'b0;
    logic          rom_sel;
    logic [PW-1:0] rom_page;
    logic [12:0]   rom_offset;
    logic [1:0]    mirror_mode;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_w0, m_w1, m_mir;

    always #2 clk = ~clk;

    prg_map #(.PAGE_COUNT(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .rom_sel(rom_sel), .rom_page(rom_page),
        .rom_offset(rom_offset), .mirror_mode(mirror_mode)
    );

    // behavioural reference
    always @(posedge clk) begin
        if (!rst_n) begin
            m_w0 = 0; m_w1 = 1; m_mir = 0;
        end else if (cpu_wr) begin
            if (cpu_addr == 16'h8010) m_w0 = int'(cpu_data) % PC;
            if (cpu_addr == 16'hA010) m_w1 = int'(cpu_data) % PC;
            if (cpu_addr == 16'h9400) m_mir = int'(cpu_data) & 3;
        end
    end

    function automatic int exp_page(input int a);
        if (a < 32768) return 0;
        case ((a >> 13) & 3)
            0: return m_w0;
            1: return m_w1;
            2: return PC - 2;
            default: return PC - 1;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic w, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = w;
        #1;
        check(tag, "rom_page", int'(rom_page), exp_page(int'(a)));
        check("R7", "rom_sel", int'(rom_sel), int'(a[15]));
        check("R7", "rom_offset", int'(rom_offset), int'(a) & 16'h1FFF);
        check("R4", "mirror_mode", int'(mirror_mode), m_mir);
    endtask

    task automatic sweep(input string tag);
        step(16'h0123, 8'h00, 1'b0, "R7");
        step(16'h8000, 8'h00, 1'b0, tag);
        step(16'h9FFF, 8'h00, 1'b0, tag);
        step(16'hA000, 8'h00, 1'b0, tag);
        step(16'hBABC, 8'h00, 1'b0, tag);
        step(16'hC000, 8'h00, 1'b0, "R3");
        step(16'hDFFF, 8'h00, 1'b0, "R3");
        step(16'hE000, 8'h00, 1'b0, "R3");
        step(16'hFFFF, 8'h00, 1'b0, "R3");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R5 reset state
        sweep("R5");
        // R1 window 0 selection, including wrap (R8)
        step(16'h8010, 8'd5, 1'b1, "R1");
        sweep("R1");
        step(16'h8010, 8'hFF, 1'b1, "R8");
        sweep("R8");
        step(16'h8010, 8'd11, 1'b1, "R1");
        // R2 window 1 selection, including wrap to 0
        step(16'hA010, 8'd7, 1'b1, "R2");
        sweep("R2");
        step(16'hA010, 8'd12, 1'b1, "R8");
        sweep("R8");
        step(16'hA010, 8'd130, 1'b1, "R2");
        // R4 arrangement codes, upper data bits ignored
        step(16'h9400, 8'h01, 1'b1, "R4");
        step(16'h9400, 8'hFE, 1'b1, "R4");
        step(16'h9400, 8'h03, 1'b1, "R4");
        step(16'h8000, 8'h00, 1'b0, "R4");
        // R6 ignored writes
        step(16'h8011, 8'd3, 1'b1, "R6");
        step(16'h8000, 8'd3, 1'b1, "R6");
        step(16'h9401, 8'h00, 1'b1, "R6");
        step(16'hA011, 8'd2, 1'b1, "R6");
        step(16'hF000, 8'd2, 1'b1, "R6");
        step(16'hC000, 8'd2, 1'b1, "R6");
        step(16'h0010, 8'd2, 1'b1, "R6");
        step(16'h8010, 8'd4, 1'b0, "R6");
        step(16'h9400, 8'h00, 1'b0, "R6");
        sweep("R6");
        // R3 fixed region unaffected by a stream of writes
        for (int i = 0; i < 16; i++) begin
            step(16'hC000 + 16'(i * 16'h0401), 8'(i * 17), 1'b1, "R3");
        end
        // mixed pattern across all pages
        for (int i = 0; i < 20; i++) begin
            step((i % 2 == 0) ? 16'h8010 : 16'hA010, 8'(i * 37 + 1), 1'b1, "R8");
            sweep("R8");
        end
        step(16'h9400, 8'h00, 1'b1, "R4");
        step(16'h9400, 8'h02, 1'b0, "R4");
        // reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        step(16'h8000, 8'h00, 1'b0, "R5");
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R5");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule